// File: doc/BRIEF.md
# Microwire Serial EEPROM Word Reader

This block fetches one 16-bit word from a three-wire serial EEPROM that uses the classic read command. The host places a 6-bit word address on `rd_addr` and pulses `rd_start`. The block then runs the whole serial access by itself. It raises select, clocks out a 9-bit command (a start bit, the read opcode and the address, most significant bit first), and clocks in 16 data bits. It then closes the access with one extra clock pulse after select has fallen. The word appears on `rd_word` in the same cycle as a one-cycle `rd_done` strobe, and it stays there until the next read finishes.

Every half-period of the serial clock lasts `DIV` system clocks. This gives slow parts the settling time they need, and it lets a simulation use a short value.

While no read is running, the three serial pins follow a small register that the host writes directly. Reading that register back returns the live pin levels together with the EEPROM's data-out line. Software can therefore drive any access by toggling bits.

Top module: `uwire_word_reader`

## Requirements
- R1: A start pulse seen while the block is idle begins a read, and `rd_busy` is high from the next cycle. Exactly `52*DIV` cycles after the start edge, `rd_done` is high for one cycle while `rd_busy` is low. A start that is present in that done cycle begins the next read at once.
- R2: A start pulse seen while `rd_busy` is high has no effect. The current read keeps its timing and its address, and no second read follows.
- R3: Chip select is high for the first 50 half-periods of a read, which cover the command phase and the data phase.
- R4: The command is the 9-bit value `{3'b110, addr}`, sent most significant bit first, one bit per clock period. Each bit is placed on data-in while the clock is low and is held through the following high half. Data-in is low during the data phase and the closing phase.
- R5: Each half-period lasts exactly `DIV` system clocks. The serial clock is low in even half-periods and high in odd half-periods, counting from 0 at the start of the read.
- R6: Data-out is sampled in the last system cycle of each high half-period of the data phase, most significant bit first. The assembled word is presented on `rd_word` with `rd_done` and is held until the next read completes.
- R7: To close the access, select drops while the clock is low (half-period 50). The clock then goes high for one half-period with select still low (half-period 51), and afterwards returns low.
- R8: While idle, a write with `raw_we` loads the pins as follows: `raw_wdata` bit 0 drives the serial clock, bit 1 drives chip select and bit 2 drives data-in. `raw_rdata` returns bit 0 clock, bit 1 select, bit 2 data-in and bit 3 data-out, all read from the live pins.
- R9: A raw write issued while `rd_busy` is high is ignored. After the read, the pins return to the value the raw register held before that write.
- R10: While reset is held, `rd_busy`, `rd_done`, `rd_word`, the three pins and the raw register are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_start | input | 1 | Read request pulse |
| rd_addr | input | 6 | Word address sampled with an accepted start |
| rd_busy | output | 1 | A read is in progress |
| rd_done | output | 1 | One-cycle strobe marking a finished read |
| rd_word | output | 16 | Last word read |
| raw_we | input | 1 | Load the bit-bang register |
| raw_wdata | input | 3 | Bit-bang value: clock, select, data-in |
| raw_rdata | output | 4 | Pin readback: clock, select, data-in, data-out |
| ee_sk | output | 1 | Serial clock to the EEPROM |
| ee_cs | output | 1 | Chip select to the EEPROM |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The assertions take three things for granted about the inputs. The first is that `ee_do` changes only at rising serial-clock edges, so it is stable at the sampling cycle. The second is that `rd_addr` is valid in the cycle a start is accepted. The third is that raw writes which the host expects to take effect are issued only while the block is idle. The bench's EEPROM responder shifts its output on each rising serial-clock edge while select is high, and it clears itself on a clock edge seen with select low. Stimulus is applied on the falling system-clock edge. The one case that breaks the idle rule, a raw write during a read, is deliberate and is checked to have no effect.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

    localparam logic [2:0] READ_OPCODE = 3'b110;
    localparam int unsigned OPCODE_W = 3;

    // Pin bundle; packed order matches the raw register layout
    // (bit 2 data-in, bit 1 select, bit 0 clock).
    typedef struct packed {
        logic di;
        logic cs;
        logic sk;
    } pins_t;

    typedef enum logic [1:0] {
        SEG_CMD,
        SEG_DATA,
        SEG_CLOSE
    } seg_e;

    // Half-periods in one read: command bits and data bits take two
    // halves each, plus the closing low/high pair.
    function automatic int unsigned half_periods(int unsigned cmd_bits,
                                                 int unsigned data_bits);
        return 2 * (cmd_bits + data_bits) + 2;
    endfunction

endpackage

// File: rtl/uwire_divider.sv
module uwire_divider #(
    parameter int unsigned DIV = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic adv
);
    localparam int CW = $clog2(DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign adv = run && (cnt == LAST);

    // R5: the half-period counter never exceeds its programmed limit
    assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/uwire_rawreg.sv
module uwire_rawreg
    import uwire_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic        lock,
    input  logic [2:0]  wdata,
    output pins_t       q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we && !lock)
            q <= pins_t'(wdata);
    end

    // R9: host writes during a read leave the register untouched
    assert_raw_locked_R9: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(q));

endmodule

// File: rtl/uwire_seq.sv
module uwire_seq
    import uwire_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              adv,
    input  logic              ee_do,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] word,
    output pins_t             pins
);
    localparam int unsigned CMD_W    = ADDR_W + OPCODE_W;
    localparam int unsigned NPH      = half_periods(CMD_W, DATA_W);
    localparam int          PW       = $clog2(NPH);
    localparam logic [PW-1:0] CMD_END  = PW'(2 * CMD_W);
    localparam logic [PW-1:0] DATA_END = PW'(2 * (CMD_W + DATA_W));
    localparam logic [PW-1:0] PH_LAST  = PW'(NPH - 1);

    logic              busy_q;
    logic              done_q;
    logic [PW-1:0]     ph;
    logic [CMD_W-1:0]  cmd_q;
    logic [DATA_W-1:0] shr;
    logic [DATA_W-1:0] word_q;
    seg_e              seg;

    always_comb begin
        if (ph < CMD_END)
            seg = SEG_CMD;
        else if (ph < DATA_END)
            seg = SEG_DATA;
        else
            seg = SEG_CLOSE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            ph     <= '0;
            cmd_q  <= '0;
            shr    <= '0;
            word_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    ph     <= '0;
                    cmd_q  <= {READ_OPCODE, addr};
                end
            end else if (adv) begin
                if (seg == SEG_CMD && ph[0])
                    cmd_q <= cmd_q << 1;
                if (seg == SEG_DATA && ph[0])
                    shr <= {shr[DATA_W-2:0], ee_do};
                if (ph == PH_LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    word_q <= shr;
                    ph     <= '0;
                end else begin
                    ph <= ph + 1'b1;
                end
            end
        end
    end

    always_comb begin
        pins.sk = busy_q & ph[0];
        pins.cs = busy_q & (seg != SEG_CLOSE);
        pins.di = busy_q & (seg == SEG_CMD) & cmd_q[CMD_W-1];
    end

    assign busy = busy_q;
    assign done = done_q;
    assign word = word_q;

    // R1: completion strobe lasts a single cycle
    assert_done_single_R1: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R4: data-in does not move on the rising clock edge
    assert_di_hold_R4: assert property (@(posedge clk) disable iff (rst)
        busy_q && $rose(pins.sk) |-> $stable(pins.di));

    // R7: select falls only while the clock is low
    assert_close_order_R7: assert property (@(posedge clk) disable iff (rst)
        busy_q && $fell(pins.cs) |-> !pins.sk);

endmodule

// File: rtl/uwire_word_reader.sv
module uwire_word_reader
    import uwire_pkg::*;
#(
    parameter int unsigned DIV    = 100,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_start,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_busy,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_word,
    input  logic              raw_we,
    input  logic [2:0]        raw_wdata,
    output logic [3:0]        raw_rdata,
    output logic              ee_sk,
    output logic              ee_cs,
    output logic              ee_di,
    input  logic              ee_do
);
    logic  adv;
    logic  busy;
    pins_t seq_pins;
    pins_t raw_pins;
    pins_t pins;

    uwire_divider #(.DIV(DIV)) u_div (
        .clk (clk),
        .rst (rst),
        .run (busy),
        .adv (adv)
    );

    uwire_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (rd_start),
        .addr  (rd_addr),
        .adv   (adv),
        .ee_do (ee_do),
        .busy  (busy),
        .done  (rd_done),
        .word  (rd_word),
        .pins  (seq_pins)
    );

    uwire_rawreg u_raw (
        .clk   (clk),
        .rst   (rst),
        .we    (raw_we),
        .lock  (busy),
        .wdata (raw_wdata),
        .q     (raw_pins)
    );

    assign pins      = busy ? seq_pins : raw_pins;
    assign ee_sk     = pins.sk;
    assign ee_cs     = pins.cs;
    assign ee_di     = pins.di;
    assign rd_busy   = busy;
    assign raw_rdata = {ee_do, pins.di, pins.cs, pins.sk};

    // R5: the serial clock holds between half-period boundaries
    assert_sk_hold_R5: assert property (@(posedge clk) disable iff (rst)
        rd_busy && !adv |=> $stable(ee_sk));

    // R2: a start during a read never cuts it short
    assert_start_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        rd_busy && rd_start |=> rd_busy || rd_done);

    // R1: completion is reported only with busy low
    assert_done_idle_R1: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> !rd_busy);

endmodule

// File: tb/tb_uwire_word_reader.sv
module tb_uwire_word_reader;

    localparam int DIV  = 3;
    localparam int NPH  = 52;
    localparam int TOT  = NPH * DIV;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_start = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic        rd_busy, rd_done;
    logic [15:0] rd_word;
    logic        raw_we = 1'b0;
    logic [2:0]  raw_wdata = '0;
    logic [3:0]  raw_rdata;
    logic        ee_sk, ee_cs, ee_di;
    logic        ee_do = 1'b0;

    always #2 clk = ~clk;

    uwire_word_reader #(.DIV(DIV)) dut (
        .clk(clk), .rst(rst), .rd_start(rd_start), .rd_addr(rd_addr),
        .rd_busy(rd_busy), .rd_done(rd_done), .rd_word(rd_word),
        .raw_we(raw_we), .raw_wdata(raw_wdata), .raw_rdata(raw_rdata),
        .ee_sk(ee_sk), .ee_cs(ee_cs), .ee_di(ee_di), .ee_do(ee_do)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    bit cmp_on = 0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    logic [15:0] mem [64];

    // EEPROM responder
    int          ecnt = 0;
    logic [8:0]  ecmd = '0;
    logic [15:0] eword;
    logic [5:0]  exp_cmd_addr = '0;
    always @(posedge ee_sk) begin
        if (!ee_cs) begin
            ecnt = 0;
        end else begin
            if (ecnt < 9) begin
                ecmd = {ecmd[7:0], ee_di};
            end else if (ecnt < 25) begin
                if (ecnt == 9) begin
                    chk("R4", "command opcode", 32'(ecmd[8:6]), 32'(3'b110));
                    chk("R4", "command address", 32'(ecmd[5:0]), 32'(exp_cmd_addr));
                end
                eword = mem[ecmd[5:0]];
                ee_do = eword[24 - ecnt];
            end
            ecnt++;
        end
    end

    // Reference model: elapsed cycles since an accepted start
    bit          run = 0;
    int          t = 0;
    bit          bz;
    logic [2:0]  raw_m = '0;
    logic [15:0] word_m = '0;
    logic [5:0]  addr_m = '0;

    always @(posedge clk) begin
        bz = run && (t < TOT);
        if (rst) begin
            run = 0; t = 0; raw_m = '0; word_m = '0;
        end else begin
            if (raw_we && !bz) raw_m = raw_wdata;
            if (rd_start && !bz) begin
                run = 1; t = 0; addr_m = rd_addr;
            end else if (run) begin
                if (t < TOT) begin
                    t++;
                    if (t == TOT) word_m = mem[addr_m];
                end else begin
                    run = 0;
                end
            end
        end
    end

    int         p;
    logic       e_busy, e_done, e_sk, e_cs, e_di;
    logic [8:0] e_cmd;
    always @(negedge clk) begin
        if (!rst && cmp_on) begin
            e_busy = run && (t < TOT);
            e_done = run && (t == TOT);
            e_cmd  = {3'b110, addr_m};
            p = t / DIV;
            if (e_busy) begin
                e_sk = (p % 2) == 1;
                e_cs = p < 50;
                e_di = (p < 18) ? e_cmd[8 - p/2] : 1'b0;
            end else begin
                {e_di, e_cs, e_sk} = raw_m;
            end
            chk("R1", "busy", 32'(rd_busy), 32'(e_busy));
            chk("R1", "done", 32'(rd_done), 32'(e_done));
            chk("R6", "word", 32'(rd_word), 32'(word_m));
            chk("R5", "sk", 32'(ee_sk), 32'(e_sk));
            chk((e_busy && p >= 50) ? "R7" : "R3", "cs", 32'(ee_cs), 32'(e_cs));
            chk("R4", "di", 32'(ee_di), 32'(e_di));
            chk("R8", "raw readback", 32'(raw_rdata), 32'({ee_do, e_di, e_cs, e_sk}));
        end
    end

    task automatic do_read(input logic [5:0] a);
        @(negedge clk);
        rd_addr = a; exp_cmd_addr = a; rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        repeat (TOT + 2) @(negedge clk);
    endtask

    task automatic rw(input logic [2:0] v);
        @(negedge clk);
        raw_we = 1'b1; raw_wdata = v;
        @(negedge clk);
        raw_we = 1'b0;
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        #(4 * 60000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    logic [15:0] bb_word;
    logic [8:0]  bb_cmd;

    initial begin
        for (int i = 0; i < 64; i++)
            mem[i] = 16'(i * 16'h1357) ^ 16'h5A3C;
        mem[0]  = 16'h0000;
        mem[63] = 16'hFFFF;
        mem[21] = 16'hAAAA;
        mem[42] = 16'h5555;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10", "busy", 32'(rd_busy), 0);
        chk("R10", "done", 32'(rd_done), 0);
        chk("R10", "word", 32'(rd_word), 0);
        chk("R10", "pins", 32'({ee_di, ee_cs, ee_sk}), 0);
        chk("R10", "raw readback", 32'(raw_rdata), 0);
        rst = 1'b0;
        cmp_on = 1;
        repeat (2) @(negedge clk);

        do_read(6'd0);  chk("R6", "word addr 0",  32'(rd_word), 32'(mem[0]));
        do_read(6'd63); chk("R6", "word addr 63", 32'(rd_word), 32'(mem[63]));
        do_read(6'd21); chk("R6", "word addr 21", 32'(rd_word), 32'(mem[21]));
        do_read(6'd42); chk("R6", "word addr 42", 32'(rd_word), 32'(mem[42]));

        // R2: start during a read is ignored
        @(negedge clk);
        rd_addr = 6'd10; exp_cmd_addr = 6'd10; rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        repeat (30) @(negedge clk);
        rd_addr = 6'd33; rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        repeat (TOT) @(negedge clk);
        chk("R2", "word after ignored start", 32'(rd_word), 32'(mem[10]));
        chk("R2", "no second read", 32'(rd_busy), 0);

        // R1: start held high gives back-to-back reads
        @(negedge clk);
        rd_addr = 6'd17; exp_cmd_addr = 6'd17; rd_start = 1'b1;
        repeat (TOT + 3) @(negedge clk);
        chk("R1", "restart in done cycle", 32'(rd_busy), 1);
        rd_start = 1'b0;
        repeat (TOT + 2) @(negedge clk);
        chk("R1", "second word", 32'(rd_word), 32'(mem[17]));

        // R9: raw write during a read is ignored
        @(negedge clk);
        rd_addr = 6'd7; exp_cmd_addr = 6'd7; rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        repeat (20) @(negedge clk);
        raw_we = 1'b1; raw_wdata = 3'b111;
        @(negedge clk);
        raw_we = 1'b0;
        repeat (TOT) @(negedge clk);
        chk("R9", "pins after read", 32'({ee_di, ee_cs, ee_sk}), 0);
        chk("R6", "word addr 7", 32'(rd_word), 32'(mem[7]));

        // R8: raw pin control when idle
        rw(3'b101);
        chk("R8", "raw pins 101", 32'({ee_di, ee_cs, ee_sk}), 32'(3'b101));
        rw(3'b000);
        chk("R8", "raw pins 000", 32'({ee_di, ee_cs, ee_sk}), 0);

        // R8: full read by bit-banging address 5
        bb_cmd = {3'b110, 6'd5};
        exp_cmd_addr = 6'd5;
        rw(3'b010);
        for (int i = 8; i >= 0; i--) begin
            rw({bb_cmd[i], 2'b10});
            rw({bb_cmd[i], 2'b11});
        end
        rw(3'b010);
        bb_word = '0;
        for (int i = 0; i < 16; i++) begin
            rw(3'b011);
            bb_word = {bb_word[14:0], raw_rdata[3]};
            rw(3'b010);
        end
        rw(3'b000);
        rw(3'b001);
        rw(3'b000);
        chk("R8", "bit-bang word", 32'(bb_word), 32'(mem[5]));

        do_read(6'd12); chk("R6", "word addr 12", 32'(rd_word), 32'(mem[12]));

        finished = 1;
        summary();
        $finish;
    end

endmodule